// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic core of a small 8-bit controller. It owns the accumulator and three condition flags (zero, carry, overflow). On each clock edge where an operation is presented as valid, it combines the accumulator with an operand, writes the result back, and updates the flags the operation affects. Branch logic elsewhere reads the flags.

Carry is a not-borrow on subtraction: it reads 1 when no borrow occurred. Logical operations and loads leave carry and overflow untouched, so a compare-and-branch sequence can run logic in between without losing its condition. Decode, register indexing and memory access are outside the block.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator is 0, zero is 1, carry is 0 and overflow is 0.
- R2: Opcode 1 (add) writes (acc + operand) mod 2^W and sets carry to the bit carried out of the top bit.
- R3: Opcode 2 (add with carry) writes acc + operand + carry, with the carry flag as carry-in and carry-out as for R2.
- R4: Opcode 3 (subtract) writes acc - operand; carry is 0 when the unsigned result underflows and 1 otherwise.
- R5: Opcode 4 (subtract with carry) writes acc - operand - (1 - carry), with carry set as for R4.
- R6: On opcodes 1 to 4, overflow is 1 exactly when the signed two's complement result lies outside the W-bit range.
- R7: Opcodes 0 (load operand), 5 (and), 6 (or) and 7 (xor) write their result and leave carry and overflow unchanged.
- R8: Opcode 8 (shift left) shifts in 0 at bit 0; carry takes the old top bit, overflow is the old top bit XOR the old next bit.
- R9: Opcode 9 (shift right) shifts in 0 at the top bit; carry takes the old bit 0, overflow is cleared.
- R10: After every update, zero is 1 exactly when the accumulator is 0.
- R11: With valid low, or an opcode from 10 to 15, accumulator and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute the presented operation this edge |
| op_code | input | 4 | Operation select (see requirements) |
| operand | input | W | Second operand |
| acc | output | W | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench builds the block at its default width W = 8, where the carry and overflow boundaries sit at the byte values 0x7F, 0x80 and 0xFF and can be reached with short directed operand chains. Directed sequences walk carry through add, add-with-carry and the borrow-in of subtract-with-carry, then run logic ops between arithmetic ones to show the flags persist. A stream of random opcodes, including unused codes and idle cycles, then runs against an integer reference model that computes signed and unsigned ranges without bit tricks.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam int MSB = W - 1;

  logic         is_sub, is_arith, is_logic, is_shl, is_shr, upd;
  logic         cin;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [W-1:0] res;
  logic         c_nxt, v_nxt;

  assign is_sub   = (op_code == 4'd3) || (op_code == 4'd4);
  assign is_arith = (op_code >= 4'd1) && (op_code <= 4'd4);
  assign is_logic = (op_code == 4'd0) || ((op_code >= 4'd5) && (op_code <= 4'd7));
  assign is_shl   = (op_code == 4'd8);
  assign is_shr   = (op_code == 4'd9);
  assign upd      = op_valid && (is_arith || is_logic || is_shl || is_shr);

  assign b_eff = is_sub ? ~operand : operand;
  always_comb begin
    case (op_code)
      4'd1:    cin = 1'b0;
      4'd3:    cin = 1'b1;
      default: cin = flag_c;
    endcase
  end
  assign sum = {1'b0, acc} + {1'b0, b_eff} + {{W{1'b0}}, cin};

  always_comb begin
    res   = acc;
    c_nxt = flag_c;
    v_nxt = flag_v;
    case (op_code)
      4'd0: res = operand;
      4'd1, 4'd2, 4'd3, 4'd4: begin
        res   = sum[W-1:0];
        c_nxt = sum[W];
        v_nxt = (acc[MSB] == b_eff[MSB]) && (sum[MSB] != acc[MSB]);
      end
      4'd5: res = acc & operand;
      4'd6: res = acc | operand;
      4'd7: res = acc ^ operand;
      4'd8: begin
        res   = {acc[W-2:0], 1'b0};
        c_nxt = acc[MSB];
        v_nxt = acc[MSB] ^ acc[MSB-1];
      end
      4'd9: begin
        res   = {1'b0, acc[W-1:1]};
        c_nxt = acc[0];
        v_nxt = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      flag_z <= 1'b1;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (upd) begin
      acc    <= res;
      flag_z <= (res == '0);
      flag_c <= c_nxt;
      flag_v <= v_nxt;
    end
  end

  // R10
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z == (acc == '0));

  // R7
  logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic) |=> ($stable(flag_c) && $stable(flag_v)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(acc) && $stable(flag_c) && $stable(flag_v) && $stable(flag_z)));

  // R9
  shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_shr) |=> (flag_c == $past(acc[0]) && !flag_v && !acc[MSB]));

  // R8
  shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_shl) |=> (flag_c == $past(acc[MSB]) && !acc[0]));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [3:0] op_code = '0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] acc;
  logic flag_z, flag_c, flag_v;

  always #5 clk = ~clk;

  acc_alu #(.W(W)) u_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc(acc), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct {
    string  tag;
    int     a;
    bit     z, c, v;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_a = 0;
  bit m_z = 1, m_c = 0, m_v = 0;

  function automatic int sgn(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  task automatic compare(string tag, int a, bit z, bit c, bit v);
    n_cmp++;
    if (acc !== a[W-1:0] || flag_z !== z || flag_c !== c || flag_v !== v) begin
      n_bad++;
      $display("FAIL %s: acc=%h z=%b c=%b v=%b expected acc=%h z=%b c=%b v=%b",
               tag, acc, flag_z, flag_c, flag_v, a[W-1:0], z, c, v);
    end
  endtask

  task automatic apply(string tag, bit vld, int op, int b);
    int t, s;
    @(negedge clk);
    op_valid = vld; op_code = op[3:0]; operand = b[W-1:0];
    if (vld && op <= 9) begin
      case (op)
        0: m_a = b;
        1, 2: begin
          t = m_a + b + ((op == 2) ? int'(m_c) : 0);
          s = sgn(m_a) + sgn(b) + ((op == 2) ? int'(m_c) : 0);
          m_a = t % 256; m_c = (t > 255); m_v = (s > 127 || s < -128);
        end
        3, 4: begin
          t = m_a - b - ((op == 4) ? 1 - int'(m_c) : 0);
          s = sgn(m_a) - sgn(b) - ((op == 4) ? 1 - int'(m_c) : 0);
          m_a = (t + 512) % 256; m_c = (t >= 0); m_v = (s > 127 || s < -128);
        end
        5: m_a = m_a & b;
        6: m_a = m_a | b;
        7: m_a = m_a ^ b;
        8: begin
          s = sgn(m_a) * 2;
          m_c = (m_a >= 128); m_v = (s > 127 || s < -128);
          m_a = (m_a * 2) % 256;
        end
        default: begin
          m_c = m_a % 2; m_v = 0; m_a = m_a / 2;
        end
      endcase
      m_z = (m_a == 0);
    end
    @(posedge clk);
    #1;
    q.push_back('{tag, m_a, m_z, m_c, m_v});
    op_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.tag, e.a, e.z, e.c, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    #23;
    compare("R1 reset", 0, 1, 0, 0);
    rst_n = 1;
    apply("R7 load", 1, 0, 8'h7F);
    apply("R2 R6 add signed ovf", 1, 1, 8'h01);
    apply("R2 R6 R10 add wrap", 1, 1, 8'h80);
    apply("R3 adc with carry", 1, 2, 8'h05);
    apply("R4 sub underflow", 1, 3, 8'h07);
    apply("R5 sbc borrow-in", 1, 4, 8'h00);
    apply("R5 R10 sbc no borrow-in", 1, 4, 8'hFE);
    apply("R7 load keeps c", 1, 0, 8'h80);
    apply("R4 R6 sub signed ovf", 1, 3, 8'h01);
    apply("R7 and", 1, 5, 8'h0F);
    apply("R7 or", 1, 6, 8'h30);
    apply("R7 R10 xor to zero", 1, 7, 8'h3F);
    apply("R7 load", 1, 0, 8'hC1);
    apply("R8 shl", 1, 8, 0);
    apply("R8 shl ovf", 1, 8, 0);
    apply("R9 shr", 1, 9, 0);
    apply("R11 idle", 0, 1, 8'hFF);
    apply("R11 unused code", 1, 12, 8'h55);
    apply("R7 load", 1, 0, 8'h01);
    apply("R9 R10 shr to zero", 1, 9, 0);
    apply("R3 adc carry set", 1, 2, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 15);
      bit vl = ($urandom_range(0, 7) != 0);
      apply("R2-mix random", vl, op, $urandom_range(0, 255));
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule